// File: doc/BRIEF.md
# Designator-Addressed Scratchpad Register Bank

This block is a bank of sixteen 16-bit general registers, none of which has a fixed role. Three 4-bit designators pick the roles. The program-counter designator and the data-pointer designator are inputs from the sequencer. The operand designator is the low nibble of the current opcode. For each machine cycle the block decodes the cycle kind and the opcode nibbles. From these it presents the chosen register as the memory address, flags whether memory is referenced, and schedules an update to that register. The update can be an increment, a decrement, a byte write from the accumulator, or a clear.

A byte read port always shows one half of the register named by the opcode low nibble. The accumulator path picks this value up for the low-byte and high-byte copy opcodes. Updates are committed only on the clock edge that ends a machine cycle, which the sequencer marks with a strobe. Reads during a cycle therefore always see the values from before that cycle.

Top module: `regsel_bank`

## Requirements
- R1: After asynchronous reset, every register reads as 0000.
- R2: With cycle kind 0 (fetch), the address is R(P), memory is referenced, and R(P) increments at cycle end.
- R3: With cycle kind 1 (execute), these opcodes address R(X) and reference memory:
  - 60–67, 70–72: R(X) increments.
  - 73: R(X) decrements.
  - 69–6F, 74, 75, 77, 78, F0–F5, F7: R(X) is unchanged.
- R4: Opcodes 0N and 5N address R(N) and leave it unchanged. Opcode 4N addresses R(N) and increments it.
- R5: Opcodes F8–FD, FF, 7C, 7D and 7F address R(P), reference memory and increment R(P).
- R6: Opcode 1N increments R(N) and opcode 2N decrements it, modulo 2^16, without referencing memory.
- R7: Opcode AN writes the accumulator byte into the low byte of R(N). Opcode BN writes it into the high byte. The other byte is kept.
- R8: The byte output is the high byte of R(N) when the opcode high nibble is 9, and the low byte otherwise.
- R9: With cycle kind 2 (DMA), the address is R(0) whatever P and X hold, memory is referenced, and R(0) increments.
- R10: With cycle kind 3 (init), R(0) is cleared, no memory is referenced, and the other registers keep their values.
- R11: No register changes while the cycle-end strobe is low. Reads made during an updating cycle return the value from before the update.
- R12: All other execute opcodes (3x, 68, 76, 79–7B, 7E, 8x, 9x, Cx–Ex, F6, FE) reference no memory and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_kind | input | 2 | 0 fetch, 1 execute, 2 DMA, 3 init |
| cyc_end | input | 1 | Commits the scheduled update on this edge |
| pc_sel | input | 4 | Program-counter designator |
| dp_sel | input | 4 | Data-pointer designator |
| op_hi | input | 4 | Opcode high nibble |
| op_lo | input | 4 | Opcode low nibble (operand designator) |
| acc_in | input | 8 | Accumulator byte for byte writes |
| mem_addr | output | 16 | Value of the selected register |
| mem_ref | output | 1 | The cycle references memory |
| rd_byte | output | 8 | Chosen half of R(N) |

## Verification
Random streams mix all four cycle kinds with every opcode and with independent P, X and N values. A lookup-based model flags any opcode that picks the wrong designator or the wrong update. Directed runs give each designator a different target register, so a confused P/X/N choice appears at once in the address. A register is preloaded with FFFF or 0000 and then stepped, which separates correct wrap from a saturating or carry-leaking counter. Strobe-low cycles and same-cycle read/write cycles separate committed updates from early or unqualified ones.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_EXEC  = 2'd1,
    CYC_DMA   = 2'd2,
    CYC_INIT  = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    UPD_NONE = 3'd0,
    UPD_INC  = 3'd1,
    UPD_DEC  = 3'd2,
    UPD_LDLO = 3'd3,
    UPD_LDHI = 3'd4,
    UPD_CLR  = 3'd5
  } upd_op_e;
endpackage

// File: rtl/regsel_decode.sv
module regsel_decode
  import regsel_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_e     cyc,
  input  logic [IW-1:0] pc_sel,
  input  logic [IW-1:0] dp_sel,
  input  logic [3:0]    op_hi,
  input  logic [3:0]    op_lo,
  output logic [IW-1:0] sel,
  output upd_op_e       upd,
  output logic          mref
);
  logic [IW-1:0] n_sel;
  assign n_sel = op_lo[IW-1:0];

  always_comb begin
    sel  = '0;
    upd  = UPD_NONE;
    mref = 1'b0;
    unique case (cyc)
      CYC_FETCH: begin sel = pc_sel; upd = UPD_INC; mref = 1'b1; end
      CYC_DMA:   begin sel = '0;     upd = UPD_INC; mref = 1'b1; end
      CYC_INIT:  begin sel = '0;     upd = UPD_CLR; end
      default: begin
        case (op_hi)
          4'h0: begin sel = n_sel; mref = 1'b1; end
          4'h1: begin sel = n_sel; upd = UPD_INC; end
          4'h2: begin sel = n_sel; upd = UPD_DEC; end
          4'h4: begin sel = n_sel; mref = 1'b1; upd = UPD_INC; end
          4'h5: begin sel = n_sel; mref = 1'b1; end
          4'h6: begin
            if (op_lo != 4'h8) begin
              sel  = dp_sel;
              mref = 1'b1;
              if (op_lo < 4'h8) upd = UPD_INC;
            end
          end
          4'h7: begin
            case (op_lo)
              4'h0, 4'h1, 4'h2: begin sel = dp_sel; mref = 1'b1; upd = UPD_INC; end
              4'h3:             begin sel = dp_sel; mref = 1'b1; upd = UPD_DEC; end
              4'h4, 4'h5, 4'h7, 4'h8: begin sel = dp_sel; mref = 1'b1; end
              4'hC, 4'hD, 4'hF: begin sel = pc_sel; mref = 1'b1; upd = UPD_INC; end
              default: ;
            endcase
          end
          4'hA: begin sel = n_sel; upd = UPD_LDLO; end
          4'hB: begin sel = n_sel; upd = UPD_LDHI; end
          4'hF: begin
            if (op_lo <= 4'h5 || op_lo == 4'h7) begin
              sel = dp_sel; mref = 1'b1;
            end else if (op_lo != 4'h6 && op_lo != 4'hE) begin
              sel = pc_sel; mref = 1'b1; upd = UPD_INC;
            end
          end
          default: ;
        endcase
      end
    endcase
  end

  AST_DMA_USES_R0: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == CYC_DMA |-> (sel == '0 && mref && upd == UPD_INC)); // R9
  AST_FETCH_USES_P: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == CYC_FETCH |-> (sel == pc_sel && mref && upd == UPD_INC)); // R2
  AST_INIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == CYC_INIT |-> (!mref && upd == UPD_CLR && sel == '0)); // R10
endmodule

// File: rtl/regsel_file.sv
module regsel_file
  import regsel_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 16,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  upd_op_e       upd,
  input  logic [DW-1:0] wdat,
  input  logic [IW-1:0] bidx,
  input  logic          bhi,
  output logic [AW-1:0] rdat,
  output logic [DW-1:0] bdat
);
  localparam int HB = AW - DW;

  logic [AW-1:0] r     [NREG];
  logic [AW-1:0] r_nxt [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) r_nxt[i] = r[i];
    if (en) begin
      case (upd)
        UPD_INC:  r_nxt[idx] = r[idx] + AW'(1);
        UPD_DEC:  r_nxt[idx] = r[idx] - AW'(1);
        UPD_LDLO: r_nxt[idx] = {r[idx][AW-1:DW], wdat};
        UPD_LDHI: r_nxt[idx] = {wdat, r[idx][HB-1:0]};
        UPD_CLR:  r_nxt[idx] = '0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) r[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) r[i] <= r_nxt[i];
    end
  end

  assign rdat = r[idx];
  assign bdat = bhi ? r[bidx][AW-1:HB] : r[bidx][DW-1:0];

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd == UPD_INC) |=> r[$past(idx)] == AW'($past(r[idx]) + AW'(1))); // R6
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd == UPD_DEC) |=> r[$past(idx)] == AW'($past(r[idx]) - AW'(1))); // R6
  AST_LOW_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd == UPD_LDLO) |=> r[$past(idx)] == {$past(r[idx][AW-1:DW]), $past(wdat)}); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd == UPD_CLR) |=> r[$past(idx)] == '0); // R10

  for (genvar g = 0; g < NREG; g++) begin : g_hold
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(r[g])); // R11
  end
endmodule

// File: rtl/regsel_bank.sv
module regsel_bank
  import regsel_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 16,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_kind,
  input  logic          cyc_end,
  input  logic [IW-1:0] pc_sel,
  input  logic [IW-1:0] dp_sel,
  input  logic [3:0]    op_hi,
  input  logic [3:0]    op_lo,
  input  logic [DW-1:0] acc_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ref,
  output logic [DW-1:0] rd_byte
);
  logic [IW-1:0] sel;
  upd_op_e       upd;

  regsel_decode #(.NREG(NREG)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc    (cyc_kind_e'(cyc_kind)),
    .pc_sel (pc_sel),
    .dp_sel (dp_sel),
    .op_hi  (op_hi),
    .op_lo  (op_lo),
    .sel    (sel),
    .upd    (upd),
    .mref   (mem_ref)
  );

  regsel_file #(.NREG(NREG), .AW(AW), .DW(DW)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cyc_end),
    .idx   (sel),
    .upd   (upd),
    .wdat  (acc_in),
    .bidx  (op_lo[IW-1:0]),
    .bhi   (op_hi == 4'h9),
    .rdat  (mem_addr),
    .bdat  (rd_byte)
  );

  AST_NO_UPDATE_ON_PLAIN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'd1 && (op_hi == 4'h3 || op_hi >= 4'hC && op_hi <= 4'hE)) |-> !mem_ref); // R12
endmodule

// File: tb/regsel_bank_tb.sv
module regsel_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cyc_kind;
  logic        cyc_end;
  logic [3:0]  pc_sel, dp_sel, op_hi, op_lo;
  logic [7:0]  acc_in;
  logic [15:0] mem_addr;
  logic        mem_ref;
  logic [7:0]  rd_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] ref_r [16];

  always #2 clk = ~clk;

  regsel_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cyc_end(cyc_end),
    .pc_sel(pc_sel), .dp_sel(dp_sel), .op_hi(op_hi), .op_lo(op_lo),
    .acc_in(acc_in), .mem_addr(mem_addr), .mem_ref(mem_ref), .rd_byte(rd_byte)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 inc, 2 dec, 3 low byte, 4 high byte, 5 clear
  task automatic model(input logic [1:0] c, input logic [3:0] p, x, h, l,
                       output int s, output int k, output bit m, output string tag);
    logic [7:0] op;
    op = {h, l};
    s = 0; k = 0; m = 0; tag = "R12";
    if (c == 2'd0) begin s = p; k = 1; m = 1; tag = "R2"; end
    else if (c == 2'd2) begin s = 0; k = 1; m = 1; tag = "R9"; end
    else if (c == 2'd3) begin s = 0; k = 5; tag = "R10"; end
    else if (h == 4'h0 || h == 4'h5) begin s = l; m = 1; tag = "R4"; end
    else if (h == 4'h4) begin s = l; m = 1; k = 1; tag = "R4"; end
    else if (h == 4'h1) begin s = l; k = 1; tag = "R6"; end
    else if (h == 4'h2) begin s = l; k = 2; tag = "R6"; end
    else if (h == 4'hA) begin s = l; k = 3; tag = "R7"; end
    else if (h == 4'hB) begin s = l; k = 4; tag = "R7"; end
    else if (op inside {8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFF,
                        8'h7C, 8'h7D, 8'h7F}) begin
      s = p; m = 1; k = 1; tag = "R5";
    end else if ((op >= 8'h60 && op <= 8'h67) || op inside {8'h70, 8'h71, 8'h72}) begin
      s = x; m = 1; k = 1; tag = "R3";
    end else if (op == 8'h73) begin s = x; m = 1; k = 2; tag = "R3"; end
    else if ((op >= 8'h69 && op <= 8'h6F) || op inside {8'h74, 8'h75, 8'h77, 8'h78, 8'hF7}
             || (op >= 8'hF0 && op <= 8'hF5)) begin
      s = x; m = 1; tag = "R3";
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [3:0] p, x, h, l,
                      input logic [7:0] a, input logic e);
    int s, k;
    bit m;
    string tag;
    logic [7:0] eb;
    @(negedge clk);
    cyc_kind = c; pc_sel = p; dp_sel = x; op_hi = h; op_lo = l; acc_in = a; cyc_end = e;
    #1;
    model(c, p, x, h, l, s, k, m, tag);
    check(mem_ref === m, tag, "mem_ref", {15'd0, mem_ref}, {15'd0, m});
    if (m) check(mem_addr === ref_r[s], tag, "mem_addr", mem_addr, ref_r[s]);
    eb = (h == 4'h9) ? ref_r[l][15:8] : ref_r[l][7:0];
    check(rd_byte === eb, "R8", "rd_byte (old value, R11)", {8'd0, rd_byte}, {8'd0, eb});
    @(posedge clk);
    if (e) begin
      case (k)
        1: ref_r[s] = ref_r[s] + 16'd1;
        2: ref_r[s] = ref_r[s] - 16'd1;
        3: ref_r[s][7:0]  = a;
        4: ref_r[s][15:8] = a;
        5: ref_r[s] = 16'd0;
        default: ;
      endcase
    end
  endtask

  task automatic read_reg(input int n, input string tag);
    logic [15:0] v;
    @(negedge clk);
    cyc_kind = 2'd1; cyc_end = 1'b0; op_hi = 4'h8; op_lo = 4'(n);
    #1 v[7:0] = rd_byte;
    op_hi = 4'h9;
    #1 v[15:8] = rd_byte;
    check(v === ref_r[n], tag, $sformatf("R%0d content", n), v, ref_r[n]);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_r[i] = 16'd0;
    rst_n = 1'b0; cyc_kind = 2'd1; cyc_end = 1'b0;
    pc_sel = 0; dp_sel = 0; op_hi = 4'h3; op_lo = 0; acc_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 16; i++) read_reg(i, "R1");

    // preload every register with a distinct value through byte writes (R7)
    for (int i = 0; i < 16; i++) begin
      step(2'd1, 0, 0, 4'hA, 4'(i), 8'(8'h11 * i), 1'b1);
      step(2'd1, 0, 0, 4'hB, 4'(i), 8'(8'hF0 - i), 1'b1);
    end
    for (int i = 0; i < 16; i++) read_reg(i, "R7");

    // fetch from P=3 repeatedly (R2), DMA ignores P and X (R9)
    for (int i = 0; i < 4; i++) step(2'd0, 4'd3, 4'd7, 4'h3, 4'h0, 8'h00, 1'b1);
    for (int i = 0; i < 3; i++) step(2'd2, 4'd5, 4'd9, 4'h0, 4'h4, 8'h00, 1'b1);
    read_reg(3, "R2");
    read_reg(0, "R9");

    // distinct designators: X-, N- and P-addressed opcodes (R3, R4, R5)
    step(2'd1, 4'd2, 4'd6, 4'h6, 4'h1, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'h7, 4'h3, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'hF, 4'h4, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'h4, 4'hB, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'h5, 4'hC, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'hF, 4'h8, 8'h00, 1'b1);
    step(2'd1, 4'd2, 4'd6, 4'h7, 4'hC, 8'h00, 1'b1);
    read_reg(6, "R3");
    read_reg(11, "R4");
    read_reg(2, "R5");

    // wrap: R5 = FFFF then increment; R8 = 0000 then decrement (R6)
    step(2'd1, 0, 0, 4'hA, 4'h5, 8'hFF, 1'b1);
    step(2'd1, 0, 0, 4'hB, 4'h5, 8'hFF, 1'b1);
    step(2'd1, 0, 0, 4'h1, 4'h5, 8'h00, 1'b1);
    check(ref_r[5] == 16'h0000, "R6", "model wrap", ref_r[5], 16'h0000);
    read_reg(5, "R6");
    step(2'd1, 0, 0, 4'hA, 4'h8, 8'h00, 1'b1);
    step(2'd1, 0, 0, 4'hB, 4'h8, 8'h00, 1'b1);
    step(2'd1, 0, 0, 4'h2, 4'h8, 8'h00, 1'b1);
    read_reg(8, "R6");

    // strobe low: nothing changes (R11)
    step(2'd1, 0, 0, 4'h1, 4'h9, 8'h00, 1'b0);
    step(2'd0, 4'd9, 0, 4'h3, 4'h0, 8'h00, 1'b0);
    step(2'd1, 0, 0, 4'hB, 4'h9, 8'h77, 1'b0);
    read_reg(9, "R11");
    // same-cycle read of a written register returns the old value (R11)
    step(2'd1, 0, 0, 4'hA, 4'h4, 8'h5A, 1'b1);
    read_reg(4, "R11");

    // plain opcodes touch nothing (R12)
    step(2'd1, 4'd1, 4'd1, 4'hD, 4'h1, 8'h00, 1'b1);
    step(2'd1, 4'd1, 4'd1, 4'h6, 4'h8, 8'h00, 1'b1);
    step(2'd1, 4'd1, 4'd1, 4'hF, 4'hE, 8'h00, 1'b1);
    read_reg(1, "R12");

    // init clears R(0) only (R10)
    step(2'd3, 4'd4, 4'd4, 4'h0, 4'h0, 8'h00, 1'b1);
    read_reg(0, "R10");
    read_reg(4, "R10");

    // random mix of everything
    for (int i = 0; i < 600; i++)
      step(2'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
           8'($urandom), 1'($urandom_range(0, 3) != 0));
    for (int i = 0; i < 16; i++) read_reg(i, "R11");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule